// File: doc/BRIEF.md
# Two-Block Compressed Slot Allocator

This block keeps the placement table for one set of a compressed cache. Each data way of the set has one 64-byte slot that can hold up to two variable-size compressed blocks. A block in the lower position starts at byte zero and grows upward. A block in the upper position ends on the last byte of the slot and grows downward. For every way the table keeps two tags, two valid bits and two compressed sizes. A per-way disable input hides a faulty slot from lookup and from allocation.

A lookup presents a tag and, one cycle later, receives a hit flag with the way, the position and the start byte of the block. An insert presents a tag and a compressed size. If some enabled slot has enough free room, the block goes there at once and nothing is evicted. If no slot has room, a round-robin pointer picks a victim slot. The allocator then removes that slot's residents one per cycle, reports each removed tag, and places the new block once enough room is free. Lookups and inserts may be presented in the same cycle.

Top module: `cslot_alloc`

## Requirements
- R1: After reset every slot is empty, no lookup hits, `busy_o` is low and neither `ins_done_o` nor `ev_valid_o` is asserted.
- R2: A lookup sampled on a clock edge reports its result in the cycle after that edge. A block in position 0 reports offset 0. A block in position 1 reports offset 64 minus its size.
- R3: A way whose bit in `way_dis_i` is set never produces a lookup hit, even if it still holds valid blocks.
- R4: An insert accepted while idle scans the enabled ways in ascending index order and takes the first one with room. An empty slot takes the block at position 0. A slot with one resident takes the block in the free position, but only if the two sizes sum to 64 or less. Position 1 starts at 64 minus the size. The result (`ins_done_o`, `ins_placed_o`=1, way, position, offset) appears in the next cycle, and nothing is evicted.
- R5: A block of size 64 fills its slot alone. No second block is ever placed next to it.
- R6: A disabled way is never chosen as a fit target or as a victim.
- R7: When no enabled slot has room, the victim is the first enabled way at or after the round-robin pointer, with wraparound. The pointer is 0 after reset and moves to the way after the victim.
- R8: In the victim slot, the position-1 block is evicted first. The position-0 block is evicted only if the new block still does not fit beside it. Each eviction raises `ev_valid_o` for exactly one cycle with the evicted tag, and at most one eviction occurs per cycle.
- R9: `busy_o` is high from the cycle after a victim insert is accepted until the cycle in which its `ins_done_o` appears. The done pulse comes one cycle after the last eviction. Inserts presented while `busy_o` is high are ignored.
- R10: An insert accepted while every way is disabled completes in the next cycle with `ins_placed_o`=0 and changes no slot.
- R11: A lookup in the same cycle as an insert, eviction or placement sees the table as it stood before that clock edge.
- R12: Sizes are byte counts from 1 to 64. The two residents of any slot never exceed 64 bytes together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| way_dis_i | input | NUM_WAYS | Per-way slot disable |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | TAG_W | Lookup tag |
| lk_hit_o | output | 1 | Lookup hit, one cycle after the request |
| lk_way_o | output | WAY_W | Way of the hit |
| lk_pos_o | output | 1 | Position of the hit (0 lower, 1 upper) |
| lk_off_o | output | OFF_W | Start byte of the hit block |
| ins_valid_i | input | 1 | Insert request, taken only while not busy |
| ins_tag_i | input | TAG_W | Tag of the new block |
| ins_size_i | input | SIZE_W | Compressed size in bytes, 1 to 64 |
| busy_o | output | 1 | Victim eviction in progress |
| ins_done_o | output | 1 | Insert finished (one-cycle pulse) |
| ins_placed_o | output | 1 | Insert finished with a placement |
| ins_way_o | output | WAY_W | Way given to the new block |
| ins_pos_o | output | 1 | Position given to the new block |
| ins_off_o | output | OFF_W | Start byte of the new block |
| ev_valid_o | output | 1 | Eviction report (one-cycle pulse) |
| ev_tag_o | output | TAG_W | Tag of the evicted block |

## Verification
Two things can collide in a single cycle. A lookup can target a block that an eviction or placement is changing on the same clock edge. The bench provokes this deliberately: it looks up a tag in the cycle where that tag is being evicted, and it looks up one block while a different block is being inserted. A long random phase then overlaps lookups with inserts, evictions and changes to the disable pattern. A behavioural model updates its table only after it has resolved each cycle's lookup against the old contents. Every output is compared against that model on every cycle, so a lookup that sees a half-updated slot shows up as a mismatch in hit, way, position or offset.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORK = 1'b1
    } alloc_st_e;

endpackage

// File: rtl/cslot_fit.sv
module cslot_fit #(
    parameter int NUM_WAYS   = 3,
    parameter int SLOT_BYTES = 64,
    parameter int SIZE_W     = 7,
    parameter int WAY_W      = 2
) (
    input  logic [NUM_WAYS-1:0]             v0_i,
    input  logic [NUM_WAYS-1:0]             v1_i,
    input  logic [NUM_WAYS-1:0]             dis_i,
    input  logic [NUM_WAYS-1:0][SIZE_W-1:0] s0_i,
    input  logic [NUM_WAYS-1:0][SIZE_W-1:0] s1_i,
    input  logic [SIZE_W-1:0]               size_i,
    output logic                            found_o,
    output logic [WAY_W-1:0]                way_o,
    output logic                            pos_o
);
    localparam int SUM_W = SIZE_W + 1;

    logic [NUM_WAYS-1:0] fits;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        logic [SUM_W-1:0] used;
        logic [SUM_W-1:0] need;
        always_comb begin
            used = (v0_i[g] ? {1'b0, s0_i[g]} : '0) + (v1_i[g] ? {1'b0, s1_i[g]} : '0);
            need = used + {1'b0, size_i};
        end
        assign fits[g] = !dis_i[g] && !(v0_i[g] && v1_i[g]) && (need <= SUM_W'(SLOT_BYTES));
    end

    // lowest index wins: later iterations override with smaller indices
    always_comb begin
        found_o = 1'b0;
        way_o   = '0;
        pos_o   = 1'b0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (fits[i]) begin
                found_o = 1'b1;
                way_o   = WAY_W'(i);
                pos_o   = v0_i[i];
            end
        end
    end
endmodule

// File: rtl/cslot_match.sv
module cslot_match #(
    parameter int NUM_WAYS = 3,
    parameter int TAG_W    = 16,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0]            v0_i,
    input  logic [NUM_WAYS-1:0]            v1_i,
    input  logic [NUM_WAYS-1:0]            dis_i,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] t0_i,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] t1_i,
    input  logic [TAG_W-1:0]               key_i,
    output logic                           hit_o,
    output logic [WAY_W-1:0]               way_o,
    output logic                           pos_o
);
    logic [NUM_WAYS-1:0] h0;
    logic [NUM_WAYS-1:0] h1;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign h0[g] = !dis_i[g] && v0_i[g] && (t0_i[g] == key_i);
        assign h1[g] = !dis_i[g] && v1_i[g] && (t1_i[g] == key_i);
    end

    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        pos_o = 1'b0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (h1[i]) begin
                hit_o = 1'b1;
                way_o = WAY_W'(i);
                pos_o = 1'b1;
            end
            if (h0[i]) begin
                hit_o = 1'b1;
                way_o = WAY_W'(i);
                pos_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cslot_victim.sv
module cslot_victim #(
    parameter int NUM_WAYS = 3,
    parameter int WAY_W    = 2
) (
    input  logic [WAY_W-1:0]    rr_i,
    input  logic [NUM_WAYS-1:0] dis_i,
    output logic                found_o,
    output logic [WAY_W-1:0]    way_o
);
    always_comb begin
        found_o = 1'b0;
        way_o   = '0;
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            int j;
            j = int'(rr_i) + k;
            if (j >= NUM_WAYS) j = j - NUM_WAYS;
            if (!dis_i[j]) begin
                found_o = 1'b1;
                way_o   = WAY_W'(j);
            end
        end
    end
endmodule

// File: rtl/cslot_alloc.sv
module cslot_alloc
    import cslot_pkg::*;
#(
    parameter int NUM_WAYS   = 3,
    parameter int TAG_W      = 16,
    parameter int SLOT_BYTES = 64,
    localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SIZE_W    = $clog2(SLOT_BYTES) + 1,
    localparam int OFF_W     = $clog2(SLOT_BYTES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_WAYS-1:0] way_dis_i,
    input  logic                lk_valid_i,
    input  logic [TAG_W-1:0]    lk_tag_i,
    output logic                lk_hit_o,
    output logic [WAY_W-1:0]    lk_way_o,
    output logic                lk_pos_o,
    output logic [OFF_W-1:0]    lk_off_o,
    input  logic                ins_valid_i,
    input  logic [TAG_W-1:0]    ins_tag_i,
    input  logic [SIZE_W-1:0]   ins_size_i,
    output logic                busy_o,
    output logic                ins_done_o,
    output logic                ins_placed_o,
    output logic [WAY_W-1:0]    ins_way_o,
    output logic                ins_pos_o,
    output logic [OFF_W-1:0]    ins_off_o,
    output logic                ev_valid_o,
    output logic [TAG_W-1:0]    ev_tag_o
);
    localparam int SUM_W = SIZE_W + 1;

    typedef struct packed {
        alloc_st_e                       st;
        logic [WAY_W-1:0]                rr;
        logic [WAY_W-1:0]                vic;
        logic [TAG_W-1:0]                ptag;
        logic [SIZE_W-1:0]               psize;
        logic [NUM_WAYS-1:0]             v0;
        logic [NUM_WAYS-1:0]             v1;
        logic [NUM_WAYS-1:0][TAG_W-1:0]  t0;
        logic [NUM_WAYS-1:0][TAG_W-1:0]  t1;
        logic [NUM_WAYS-1:0][SIZE_W-1:0] s0;
        logic [NUM_WAYS-1:0][SIZE_W-1:0] s1;
        logic                            lk_hit;
        logic [WAY_W-1:0]                lk_way;
        logic                            lk_pos;
        logic [OFF_W-1:0]                lk_off;
        logic                            done;
        logic                            placed;
        logic [WAY_W-1:0]                pway;
        logic                            ppos;
        logic [OFF_W-1:0]                poff;
        logic                            ev;
        logic [TAG_W-1:0]                ev_tag;
    } alloc_reg_t;

    alloc_reg_t q, d;

    logic             fit_found, fit_pos, m_hit, m_pos, vic_found;
    logic [WAY_W-1:0] fit_way, m_way, vic_way;

    cslot_fit #(
        .NUM_WAYS(NUM_WAYS), .SLOT_BYTES(SLOT_BYTES), .SIZE_W(SIZE_W), .WAY_W(WAY_W)
    ) i_fit (
        .v0_i(q.v0), .v1_i(q.v1), .dis_i(way_dis_i), .s0_i(q.s0), .s1_i(q.s1),
        .size_i(ins_size_i), .found_o(fit_found), .way_o(fit_way), .pos_o(fit_pos)
    );

    cslot_match #(
        .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) i_match (
        .v0_i(q.v0), .v1_i(q.v1), .dis_i(way_dis_i), .t0_i(q.t0), .t1_i(q.t1),
        .key_i(lk_tag_i), .hit_o(m_hit), .way_o(m_way), .pos_o(m_pos)
    );

    cslot_victim #(
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
    ) i_victim (
        .rr_i(q.rr), .dis_i(way_dis_i), .found_o(vic_found), .way_o(vic_way)
    );

    always_comb begin
        logic             pl_do;
        logic [WAY_W-1:0] pl_way;
        logic             pl_pos;
        logic [TAG_W-1:0] pl_tag;
        logic [SIZE_W-1:0] pl_size;
        logic [SUM_W-1:0] both;

        d        = q;
        d.lk_hit = 1'b0;
        d.lk_way = '0;
        d.lk_pos = 1'b0;
        d.lk_off = '0;
        d.done   = 1'b0;
        d.placed = 1'b0;
        d.ev     = 1'b0;
        pl_do    = 1'b0;
        pl_way   = '0;
        pl_pos   = 1'b0;
        pl_tag   = ins_tag_i;
        pl_size  = ins_size_i;
        both     = {1'b0, q.s0[q.vic]} + {1'b0, q.psize};

        // lookup resolves against the table before this edge
        if (lk_valid_i && m_hit) begin
            d.lk_hit = 1'b1;
            d.lk_way = m_way;
            d.lk_pos = m_pos;
            d.lk_off = m_pos ? OFF_W'(SLOT_BYTES - int'(q.s1[m_way])) : '0;
        end

        if (q.st == ST_IDLE) begin
            if (ins_valid_i) begin
                if (fit_found) begin
                    pl_do  = 1'b1;
                    pl_way = fit_way;
                    pl_pos = fit_pos;
                end else if (vic_found) begin
                    d.st    = ST_WORK;
                    d.vic   = vic_way;
                    d.rr    = (int'(vic_way) == NUM_WAYS - 1) ? '0 : vic_way + 1'b1;
                    d.ptag  = ins_tag_i;
                    d.psize = ins_size_i;
                end else begin
                    d.done = 1'b1;
                    d.pway = '0;
                    d.ppos = 1'b0;
                    d.poff = '0;
                end
            end
        end else begin
            if (q.v1[q.vic]) begin
                d.ev           = 1'b1;
                d.ev_tag       = q.t1[q.vic];
                d.v1[q.vic]    = 1'b0;
            end else if (q.v0[q.vic] && (both > SUM_W'(SLOT_BYTES))) begin
                d.ev           = 1'b1;
                d.ev_tag       = q.t0[q.vic];
                d.v0[q.vic]    = 1'b0;
            end else begin
                pl_do   = 1'b1;
                pl_way  = q.vic;
                pl_pos  = q.v0[q.vic];
                pl_tag  = q.ptag;
                pl_size = q.psize;
                d.st    = ST_IDLE;
            end
        end

        if (pl_do) begin
            if (pl_pos) begin
                d.v1[pl_way] = 1'b1;
                d.t1[pl_way] = pl_tag;
                d.s1[pl_way] = pl_size;
                d.poff       = OFF_W'(SLOT_BYTES - int'(pl_size));
            end else begin
                d.v0[pl_way] = 1'b1;
                d.t0[pl_way] = pl_tag;
                d.s0[pl_way] = pl_size;
                d.poff       = '0;
            end
            d.done   = 1'b1;
            d.placed = 1'b1;
            d.pway   = pl_way;
            d.ppos   = pl_pos;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lk_hit_o     = q.lk_hit;
    assign lk_way_o     = q.lk_way;
    assign lk_pos_o     = q.lk_pos;
    assign lk_off_o     = q.lk_off;
    assign busy_o       = (q.st == ST_WORK);
    assign ins_done_o   = q.done;
    assign ins_placed_o = q.placed;
    assign ins_way_o    = q.pway;
    assign ins_pos_o    = q.ppos;
    assign ins_off_o    = q.poff;
    assign ev_valid_o   = q.ev;
    assign ev_tag_o     = q.ev_tag;

    // ---------------- assertions ----------------
    assert_lk_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_hit_o |-> $past(lk_valid_i));

    assert_hit_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_hit_o |-> !((($past(way_dis_i)) >> lk_way_o) & NUM_WAYS'(1)));

    assert_ev_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_valid_o |-> ($past(busy_o) && !ins_done_o));

    assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_done_o |-> !busy_o);

    assert_size_in_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_valid_i && !busy_o) |-> (ins_size_i != '0 && int'(ins_size_i) <= SLOT_BYTES));

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chk
        assert_pair_fits_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q.v0[g] && q.v1[g]) |-> (int'(q.s0[g]) + int'(q.s1[g]) <= SLOT_BYTES));

        assert_full_alone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (q.v0[g] && int'(q.s0[g]) == SLOT_BYTES) |-> !q.v1[g]);
    end
endmodule

// File: tb/test_cslot_alloc.sv
`timescale 1ns/1ps
module test_cslot_alloc;
    localparam int NW   = 3;
    localparam int TW   = 16;
    localparam int SB   = 64;
    localparam int WW   = 2;
    localparam int SW   = 7;
    localparam int OW   = 6;
    localparam int WDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] dis = '0;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_tag = '0;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_tag = '0;
    logic [SW-1:0] ins_size = 7'd1;

    logic          lk_hit, lk_pos, busy, ins_done, ins_placed, ins_pos, ev_valid;
    logic [WW-1:0] lk_way, ins_way;
    logic [OW-1:0] lk_off, ins_off;
    logic [TW-1:0] ev_tag;

    always #2 clk = ~clk;

    cslot_alloc #(.NUM_WAYS(NW), .TAG_W(TW), .SLOT_BYTES(SB)) i_cslot_alloc (
        .clk_i(clk), .rst_ni(rst_n), .way_dis_i(dis),
        .lk_valid_i(lk_valid), .lk_tag_i(lk_tag), .lk_hit_o(lk_hit), .lk_way_o(lk_way),
        .lk_pos_o(lk_pos), .lk_off_o(lk_off),
        .ins_valid_i(ins_valid), .ins_tag_i(ins_tag), .ins_size_i(ins_size),
        .busy_o(busy), .ins_done_o(ins_done), .ins_placed_o(ins_placed),
        .ins_way_o(ins_way), .ins_pos_o(ins_pos), .ins_off_o(ins_off),
        .ev_valid_o(ev_valid), .ev_tag_o(ev_tag)
    );

    // ---------------- behavioural reference ----------------
    int mv0[NW], mv1[NW], mt0[NW], mt1[NW], ms0[NW], ms1[NW];
    int mbusy, mvic, mrr, mptag, mpsize;
    int e_lk_hit = 0, e_lk_way = 0, e_lk_pos = 0, e_lk_off = 0;
    int e_done = 0, e_placed = 0, e_way = 0, e_pos = 0, e_off = 0;
    int e_ev = 0, e_evtag = 0, e_busy = 0;

    task automatic put(int w, int p, int tg, int sz);
        if (p == 1) begin mv1[w] = 1; mt1[w] = tg; ms1[w] = sz; e_off = SB - sz; end
        else        begin mv0[w] = 1; mt0[w] = tg; ms0[w] = sz; e_off = 0; end
        e_done = 1; e_placed = 1; e_way = w; e_pos = p;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                mv0[w] = 0; mv1[w] = 0; mt0[w] = 0; mt1[w] = 0; ms0[w] = 0; ms1[w] = 0;
            end
            mbusy = 0; mvic = 0; mrr = 0; mptag = 0; mpsize = 0;
            e_lk_hit = 0; e_done = 0; e_placed = 0; e_ev = 0; e_busy = 0;
        end else begin
            e_lk_hit = 0; e_done = 0; e_placed = 0; e_ev = 0;
            if (lk_valid) begin
                for (int w = 0; w < NW; w++) begin
                    if (!dis[w] && !e_lk_hit) begin
                        if (mv0[w] != 0 && mt0[w] == int'(lk_tag)) begin
                            e_lk_hit = 1; e_lk_way = w; e_lk_pos = 0; e_lk_off = 0;
                        end else if (mv1[w] != 0 && mt1[w] == int'(lk_tag)) begin
                            e_lk_hit = 1; e_lk_way = w; e_lk_pos = 1; e_lk_off = SB - ms1[w];
                        end
                    end
                end
            end
            if (mbusy == 0) begin
                if (ins_valid) begin
                    int found, sz, vic;
                    found = -1; sz = int'(ins_size); vic = -1;
                    for (int w = 0; w < NW; w++) begin
                        if (!dis[w] && found < 0) begin
                            if (mv0[w] == 0 && mv1[w] == 0) found = w;
                            else if (mv0[w] != 0 && mv1[w] == 0 && ms0[w] + sz <= SB) found = w;
                            else if (mv0[w] == 0 && mv1[w] != 0 && ms1[w] + sz <= SB) found = w;
                        end
                    end
                    if (found >= 0) put(found, mv0[found], int'(ins_tag), sz);
                    else begin
                        for (int k = 0; k < NW; k++)
                            if (vic < 0 && !dis[(mrr + k) % NW]) vic = (mrr + k) % NW;
                        if (vic < 0) begin
                            e_done = 1; e_placed = 0; e_way = 0; e_pos = 0; e_off = 0;
                        end else begin
                            mbusy = 1; mvic = vic; mrr = (vic + 1) % NW;
                            mptag = int'(ins_tag); mpsize = sz;
                        end
                    end
                end
            end else begin
                if (mv1[mvic] != 0) begin
                    e_ev = 1; e_evtag = mt1[mvic]; mv1[mvic] = 0;
                end else if (mv0[mvic] != 0 && ms0[mvic] + mpsize > SB) begin
                    e_ev = 1; e_evtag = mt0[mvic]; mv0[mvic] = 0;
                end else begin
                    put(mvic, mv0[mvic], mptag, mpsize);
                    mbusy = 0;
                end
            end
            e_busy = mbusy;
        end
    end

    // ---------------- comparison and watchdog ----------------
    int checks = 0, errors = 0, cycles = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 1) begin
            chk("R2/R3/R11 lookup hit", int'(lk_hit), e_lk_hit);
            if (e_lk_hit != 0 && lk_hit) begin
                chk("R2 lookup way", int'(lk_way), e_lk_way);
                chk("R2 lookup pos", int'(lk_pos), e_lk_pos);
                chk("R2 lookup offset", int'(lk_off), e_lk_off);
            end
            chk("R4/R9/R10 insert done", int'(ins_done), e_done);
            if (e_done != 0 && ins_done) begin
                chk("R10 insert placed", int'(ins_placed), e_placed);
                chk("R4/R6/R7 insert way", int'(ins_way), e_way);
                chk("R4/R5 insert pos", int'(ins_pos), e_pos);
                chk("R4 insert offset", int'(ins_off), e_off);
            end
            chk("R8 eviction valid", int'(ev_valid), e_ev);
            if (e_ev != 0 && ev_valid) chk("R8 eviction tag", int'(ev_tag), e_evtag);
            chk("R9 busy", int'(busy), e_busy);
        end
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d cycles expected at most %0d", cycles, WDOG);
            finish_run();
        end
    end

    task automatic cyc(input bit lv, input int lt, input bit iv, input int it, input int isz);
        @(negedge clk);
        lk_valid  = lv;
        lk_tag    = TW'(lt);
        ins_valid = iv;
        ins_tag   = TW'(it);
        ins_size  = SW'(isz);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
    endtask

    initial begin
        int tagc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty table after reset
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(ins_done), 0);
        chk("R1 eviction after reset", int'(ev_valid), 0);
        cyc(1, 'h0A, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R1 lookup on empty table", int'(lk_hit), 0);

        // R4: fits in ascending order; R5: full-size block alone
        cyc(0, 0, 1, 'h0A, 20);
        cyc(0, 0, 1, 'h0B, 30);
        cyc(0, 0, 1, 'h0C, 64);
        // R11: lookup alongside an insert
        cyc(1, 'h0A, 1, 'h0D, 15);
        cyc(1, 'h0B, 1, 'h0E, 49);
        cyc(1, 'h0C, 0, 0, 1);
        cyc(1, 'h0E, 0, 0, 1);
        idle(1);

        // R7 R8: victim way 0, evict upper block, lookup it during eviction
        cyc(0, 0, 1, 'h0F, 10);
        cyc(1, 'h0B, 0, 0, 1);
        cyc(1, 'h0B, 0, 0, 1);
        idle(3);
        // R8: lower block evicted when still too small
        cyc(0, 0, 1, 'h10, 60);
        cyc(1, 'h0C, 0, 0, 1);
        idle(3);

        // R3 R6: disabled way hidden from lookup and allocation
        dis = 3'b010;
        cyc(1, 'h10, 0, 0, 1);
        cyc(0, 0, 1, 'h11, 4);
        idle(4);

        // R9: inserts while busy are ignored
        cyc(0, 0, 1, 'h12, 64);
        cyc(0, 0, 1, 'h13, 5);
        cyc(0, 0, 1, 'h13, 5);
        idle(4);

        // R10: all ways disabled
        dis = 3'b111;
        cyc(0, 0, 1, 'h14, 8);
        idle(2);
        dis = 3'b000;

        // R12 and overlap: random mix of lookups, inserts, disable patterns
        tagc = 'h100;
        for (int n = 0; n < 4000; n++) begin
            int r;
            if (n % 250 == 0) dis = (($urandom % 4) == 0) ? NW'($urandom % 8) : '0;
            r = int'($urandom % 16);
            cyc(($urandom % 2) == 1, tagc - r, ($urandom % 2) == 1, tagc,
                (($urandom % 3) == 0) ? 33 + int'($urandom % 32) : 1 + int'($urandom % 32));
            tagc++;
        end
        idle(6);
        finish_run();
    end
endmodule